// File: doc/BRIEF.md
# Transmit Completion Interrupt Controller

This block gathers the event sources of a packet network controller into one interrupt status word. The sources are a finished transmission, an emptied transmit queue, a received frame, an early-receive byte threshold, and a fatal transmit error. Every source except transmit completion is held in a sticky bit. The host clears a sticky bit by writing a one to its position through the acknowledge strobe. A per-bit mask decides which status bits can raise the interrupt line.

Packet numbers of finished transmissions are kept in arrival order in a completion queue. The host reads the head entry and removes it by acknowledging the transmit-completion bit. That bit is therefore set for exactly as long as the queue holds an entry.

The auto-release mode changes what gets queued. With auto-release on, packets that complete without a fatal error are dropped silently, and only a fatal failure queues a number and stops the empty report. Whether an error counts as fatal depends on the duplex mode and on two enable inputs.

The interrupt is steered to one of four output pins. The three pins that are not selected have their output enable low, so they are tri-stated.

Top module: `tx_irq_ctrl`

## Requirements
- R1: After reset, `status_o` is 0, `done_valid_o` is 0 and `irq_o` is 0.
- R2: A completion on `tx_done_i` is fatal in the cases listed below. Bit 4 of the status (error) is set on the clock edge that samples that completion. The error field `err_i` is laid out as [4] 16 collisions, [3] SQE test fail, [2] FIFO underrun, [1] carrier lost, [0] late collision.
  - Underrun (`err_i[2]`) is fatal in any duplex mode.
  - With `full_duplex_i` low, a 16-collision event is fatal.
  - With `full_duplex_i` low, a late collision is fatal.
  - With `full_duplex_i` low, SQE fail is fatal when `stop_sqe_i` is high.
  - With `full_duplex_i` low, carrier loss is fatal when `mon_carrier_i` is high.
- R3: With `auto_rel_i` low, every completion pushes `tx_pkt_i` into the completion queue in order. `done_pkt_o` shows the head entry. Status bit 0 equals `done_valid_o`. An acknowledge write with bit 0 set removes the head entry.
- R4: With `auto_rel_i` high, only fatal completions are queued. Non-fatal ones leave the queue unchanged.
- R5: Status bit 2 (empty) is set by a completion with `tx_last_i` high. In auto-release mode this happens only if the completion is not fatal. The bit then stays set until an acknowledge write has bit 2 set.
- R6: An acknowledge write clears only the sticky bits written as one; zero bits leave their status bit unchanged. A bit whose set event arrives in the same cycle as its clear stays set.
- R7: A pulse on `rx_done_i` sets status bit 1.
- R8: Status bit 3 is set when `rx_active_i` is high and `rx_cnt_i` is strictly greater than `erx_thresh_i`. An equal count does not set it, and neither does any count while `rx_active_i` is low.
- R9: `irq_oe_o` is one-hot at index `int_sel_i`. `irq_o` is high only on that pin, and only when `status_o & mask_i` is nonzero. Masked bits still read in `status_o`.
- R10: The completion queue holds `DEPTH` (64) entries, returns all of them in order, and never loses an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| full_duplex_i | input | 1 | Full-duplex mode, narrows the fatal set |
| auto_rel_i | input | 1 | Auto-release mode |
| stop_sqe_i | input | 1 | SQE fail counts as fatal |
| mon_carrier_i | input | 1 | Carrier loss counts as fatal |
| tx_done_i | input | 1 | One-cycle transmit completion event |
| tx_pkt_i | input | PKT_W | Packet number of the completion |
| tx_last_i | input | 1 | Completion was the last in the transmit queue |
| err_i | input | 5 | Error flags of the completion |
| rx_done_i | input | 1 | One-cycle frame received event |
| rx_active_i | input | 1 | A frame is being received |
| rx_cnt_i | input | CNT_W | Bytes received of current frame |
| erx_thresh_i | input | CNT_W | Early-receive threshold |
| ack_we_i | input | 1 | Acknowledge write strobe |
| ack_i | input | 5 | Acknowledge data, write-one-to-clear |
| mask_i | input | 5 | Interrupt mask, one enables |
| int_sel_i | input | 2 | Output pin select |
| status_o | output | 5 | Interrupt status word |
| done_valid_o | output | 1 | Completion queue not empty |
| done_pkt_o | output | PKT_W | Completion queue head |
| irq_o | output | 4 | Interrupt pins |
| irq_oe_o | output | 4 | Output enable per pin |

## Verification
Some properties are checked on every cycle:
- pin steering and the level of the unused pins;
- the equality of the completion bit with queue occupancy;
- the hold of the empty bit without an acknowledge;
- the setting of the error bit by an underrun;
- the silence of the queue in auto-release mode for clean full-duplex completions;
- the absence of queue overflow.

The full fatal classification table needs the bench's scenarios, and so do in-order return of many packet numbers, the set-beats-clear race and the threshold boundary of early receive.

// File: rtl/tx_irq_pkg.sv
package tx_irq_pkg;
  localparam int ST_W     = 5;
  localparam int ST_TX    = 0;
  localparam int ST_RX    = 1;
  localparam int ST_EMPTY = 2;
  localparam int ST_ERX   = 3;
  localparam int ST_ERR   = 4;

  typedef struct packed {
    logic coll16;
    logic sqe;
    logic underrun;
    logic carrier;
    logic late;
  } tx_err_t;
endpackage

// File: rtl/tx_fatal_class.sv
module tx_fatal_class
  import tx_irq_pkg::*;
(
  input  tx_err_t err_i,
  input  logic    full_duplex_i,
  input  logic    stop_sqe_i,
  input  logic    mon_carrier_i,
  output logic    fatal_o
);
  logic half_dup_fatal;

  always_comb begin
    half_dup_fatal = err_i.coll16 | err_i.late
                   | (err_i.sqe & stop_sqe_i)
                   | (err_i.carrier & mon_carrier_i);
    fatal_o = err_i.underrun | (~full_duplex_i & half_dup_fatal);
  end
endmodule

// File: rtl/tx_done_fifo.sv
module tx_done_fifo #(
  parameter int PKT_W = 6,
  parameter int DEPTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [PKT_W-1:0] data_i,
  input  logic             pop_i,
  output logic             valid_o,
  output logic             full_o,
  output logic [PKT_W-1:0] head_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_C  = PTR_W'(DEPTH - 1);

  logic [PKT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign valid_o = (count != '0);
  assign full_o  = (count == DEPTH_C);
  assign do_pop  = pop_i & valid_o;
  assign do_push = push_i & (~full_o | do_pop);
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_C) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_C) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tx_irq_status.sv
module tx_irq_status
  import tx_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ST_W-1:1] set_i,
  input  logic [ST_W-1:1] clr_i,
  output logic [ST_W-1:1] sticky_o
);
  logic [ST_W-1:1] sticky_q;

  // set beats clear so an event in the acknowledge cycle is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= (sticky_q & ~clr_i) | set_i;
  end

  assign sticky_o = sticky_q;
endmodule

// File: rtl/irq_steer.sv
module irq_steer #(
  parameter int NPIN  = 4,
  localparam int SEL_W = (NPIN > 1) ? $clog2(NPIN) : 1
) (
  input  logic             req_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [NPIN-1:0]  pin_o,
  output logic [NPIN-1:0]  oe_o
);
  for (genvar k = 0; k < NPIN; k++) begin : g_pin
    assign oe_o[k]  = (sel_i == SEL_W'(k));
    assign pin_o[k] = oe_o[k] & req_i;
  end
endmodule

// File: rtl/tx_irq_ctrl.sv
module tx_irq_ctrl
  import tx_irq_pkg::*;
#(
  parameter int PKT_W = 6,
  parameter int DEPTH = 64,
  parameter int CNT_W = 11,
  parameter int NPIN  = 4,
  localparam int SEL_W = (NPIN > 1) ? $clog2(NPIN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             full_duplex_i,
  input  logic             auto_rel_i,
  input  logic             stop_sqe_i,
  input  logic             mon_carrier_i,
  input  logic             tx_done_i,
  input  logic [PKT_W-1:0] tx_pkt_i,
  input  logic             tx_last_i,
  input  logic [4:0]       err_i,
  input  logic             rx_done_i,
  input  logic             rx_active_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [CNT_W-1:0] erx_thresh_i,
  input  logic             ack_we_i,
  input  logic [ST_W-1:0]  ack_i,
  input  logic [ST_W-1:0]  mask_i,
  input  logic [SEL_W-1:0] int_sel_i,
  output logic [ST_W-1:0]  status_o,
  output logic             done_valid_o,
  output logic [PKT_W-1:0] done_pkt_o,
  output logic [NPIN-1:0]  irq_o,
  output logic [NPIN-1:0]  irq_oe_o
);
  logic            fatal;
  logic            fifo_push, fifo_pop, fifo_full;
  logic [ST_W-1:1] st_set, st_clr, sticky;

  tx_fatal_class u_class (
    .err_i         (tx_err_t'(err_i)),
    .full_duplex_i (full_duplex_i),
    .stop_sqe_i    (stop_sqe_i),
    .mon_carrier_i (mon_carrier_i),
    .fatal_o       (fatal)
  );

  // auto-release drops clean completions; a fatal one is always reported
  assign fifo_push = tx_done_i & (~auto_rel_i | fatal);
  assign fifo_pop  = ack_we_i & ack_i[ST_TX];

  tx_done_fifo #(.PKT_W(PKT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_push),
    .data_i  (tx_pkt_i),
    .pop_i   (fifo_pop),
    .valid_o (done_valid_o),
    .full_o  (fifo_full),
    .head_o  (done_pkt_o)
  );

  always_comb begin
    st_set           = '0;
    st_set[ST_RX]    = rx_done_i;
    st_set[ST_EMPTY] = tx_done_i & tx_last_i & ~(auto_rel_i & fatal);
    st_set[ST_ERX]   = rx_active_i & (rx_cnt_i > erx_thresh_i);
    st_set[ST_ERR]   = tx_done_i & fatal;
    st_clr           = ack_we_i ? ack_i[ST_W-1:1] : '0;
  end

  tx_irq_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (st_set),
    .clr_i    (st_clr),
    .sticky_o (sticky)
  );

  assign status_o = {sticky, done_valid_o};

  irq_steer #(.NPIN(NPIN)) u_steer (
    .req_i (|(status_o & mask_i)),
    .sel_i (int_sel_i),
    .pin_o (irq_o),
    .oe_o  (irq_oe_o)
  );
endmodule

// File: rtl/tx_irq_ctrl_chk.sv
module tx_irq_ctrl_chk
  import tx_irq_pkg::*;
#(
  parameter int NPIN = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            full_duplex_i,
  input logic            auto_rel_i,
  input logic            tx_done_i,
  input logic [4:0]      err_i,
  input logic            ack_we_i,
  input logic [ST_W-1:0] ack_i,
  input logic [ST_W-1:0] status_o,
  input logic            done_valid_o,
  input logic [NPIN-1:0] irq_o,
  input logic [NPIN-1:0] irq_oe_o,
  input logic            fifo_push,
  input logic            fifo_pop,
  input logic            fifo_full
);
  p_oe_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_oe_o) == 1);

  p_unused_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~irq_oe_o) == '0);

  p_txint_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_TX] == done_valid_o);

  p_empty_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[ST_EMPTY] && !(ack_we_i && ack_i[ST_EMPTY])) |=> status_o[ST_EMPTY]);

  p_underrun_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && err_i[2]) |=> status_o[ST_ERR]);

  p_auto_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_rel_i && full_duplex_i && tx_done_i && !err_i[2] && !done_valid_o)
      |=> !done_valid_o);

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_push && fifo_full && !fifo_pop));
endmodule

bind tx_irq_ctrl tx_irq_ctrl_chk #(.NPIN(NPIN)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .full_duplex_i (full_duplex_i),
  .auto_rel_i    (auto_rel_i),
  .tx_done_i     (tx_done_i),
  .err_i         (err_i),
  .ack_we_i      (ack_we_i),
  .ack_i         (ack_i),
  .status_o      (status_o),
  .done_valid_o  (done_valid_o),
  .irq_o         (irq_o),
  .irq_oe_o      (irq_oe_o),
  .fifo_push     (fifo_push),
  .fifo_pop      (fifo_pop),
  .fifo_full     (fifo_full)
);

// File: tb/test_tx_irq_ctrl.sv
module test_tx_irq_ctrl;
  localparam int PKT_W = 6;
  localparam int DEPTH = 64;
  localparam int CNT_W = 11;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             full_duplex_i = 0, auto_rel_i = 0, stop_sqe_i = 0, mon_carrier_i = 0;
  logic             tx_done_i = 0, tx_last_i = 0;
  logic [PKT_W-1:0] tx_pkt_i = '0;
  logic [4:0]       err_i = '0;
  logic             rx_done_i = 0, rx_active_i = 0;
  logic [CNT_W-1:0] rx_cnt_i = '0, erx_thresh_i = '0;
  logic             ack_we_i = 0;
  logic [4:0]       ack_i = '0, mask_i = '0;
  logic [1:0]       int_sel_i = '0;
  logic [4:0]       status_o;
  logic             done_valid_o;
  logic [PKT_W-1:0] done_pkt_o;
  logic [3:0]       irq_o, irq_oe_o;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  tx_irq_ctrl #(.PKT_W(PKT_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_tx_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .full_duplex_i(full_duplex_i), .auto_rel_i(auto_rel_i),
    .stop_sqe_i(stop_sqe_i), .mon_carrier_i(mon_carrier_i), .tx_done_i(tx_done_i),
    .tx_pkt_i(tx_pkt_i), .tx_last_i(tx_last_i), .err_i(err_i), .rx_done_i(rx_done_i),
    .rx_active_i(rx_active_i), .rx_cnt_i(rx_cnt_i), .erx_thresh_i(erx_thresh_i),
    .ack_we_i(ack_we_i), .ack_i(ack_i), .mask_i(mask_i), .int_sel_i(int_sel_i),
    .status_o(status_o), .done_valid_o(done_valid_o), .done_pkt_o(done_pkt_o),
    .irq_o(irq_o), .irq_oe_o(irq_oe_o)
  );

  // [8] fd [7] stop_sqe [6] mon_carrier [5:1] err {coll16,sqe,under,carrier,late} [0] fatal
  localparam logic [8:0] VEC [12] = '{
    9'b0_0_0_00000_0, 9'b0_0_0_10000_1, 9'b1_0_0_10000_0, 9'b0_0_0_01000_0,
    9'b0_1_0_01000_1, 9'b1_1_0_01000_0, 9'b0_0_0_00010_0, 9'b0_0_1_00010_1,
    9'b0_0_0_00001_1, 9'b1_0_0_00001_0, 9'b1_0_0_00100_1, 9'b0_0_0_00100_1
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, sampled by the next posedge, observed at the following negedge
  task automatic tx_pulse(input logic [PKT_W-1:0] pkt, input logic [4:0] e, input logic last);
    tx_done_i = 1; tx_pkt_i = pkt; err_i = e; tx_last_i = last;
    @(negedge clk);
    tx_done_i = 0; err_i = '0; tx_last_i = 0;
  endtask

  task automatic ack(input logic [4:0] d);
    ack_we_i = 1; ack_i = d;
    @(negedge clk);
    ack_we_i = 0; ack_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(status_o == 0, "R1 status", status_o, 0);
    chk(done_valid_o == 0, "R1 valid", done_valid_o, 0);
    chk(irq_o == 0, "R1 irq", irq_o, 0);
    rst_ni = 1;
    @(negedge clk);

    // R2/R4 table: auto-release, classification and queueing per vector
    auto_rel_i = 1;
    for (int i = 0; i < 12; i++) begin
      full_duplex_i = VEC[i][8]; stop_sqe_i = VEC[i][7]; mon_carrier_i = VEC[i][6];
      tx_pulse(PKT_W'(i + 1), VEC[i][5:1], 1'b0);
      chk(status_o[4] == VEC[i][0], $sformatf("R2 fatal vec%0d", i), status_o[4], VEC[i][0]);
      chk(done_valid_o == VEC[i][0], $sformatf("R4 queue vec%0d", i), done_valid_o, VEC[i][0]);
      if (VEC[i][0])
        chk(done_pkt_o == PKT_W'(i + 1), "R4 pkt", done_pkt_o, i + 1);
      ack(5'b10001);
      chk(status_o == 0, "R6 clear", status_o, 0);
    end
    full_duplex_i = 0; stop_sqe_i = 0; mon_carrier_i = 0;

    // R5 auto: fatal last -> no empty; clean last -> empty, nothing queued
    tx_pulse(6'd7, 5'b00100, 1'b1);
    chk(status_o[2] == 0, "R5 auto fatal empty", status_o[2], 0);
    chk(done_valid_o == 1, "R4 auto fatal queued", done_valid_o, 1);
    ack(5'b10001);
    tx_pulse(6'd8, 5'b0, 1'b1);
    chk(status_o[2] == 1, "R5 auto empty", status_o[2], 1);
    chk(done_valid_o == 0, "R4 auto clean", done_valid_o, 0);
    ack(5'b00100);

    // R3 in-order completion queue
    auto_rel_i = 0;
    tx_pulse(6'd5, 5'b0, 1'b0);
    tx_pulse(6'd9, 5'b00001, 1'b0);
    tx_pulse(6'd12, 5'b0, 1'b1);
    chk(status_o[0] == 1, "R3 txint", status_o[0], 1);
    chk(done_pkt_o == 6'd5, "R3 head0", done_pkt_o, 5);
    ack(5'b00001);
    chk(done_pkt_o == 6'd9, "R3 head1", done_pkt_o, 9);
    ack(5'b00001);
    chk(done_pkt_o == 6'd12, "R3 head2", done_pkt_o, 12);
    ack(5'b00001);
    chk(done_valid_o == 0, "R3 drained", done_valid_o, 0);

    // R5 hold and R6 zero bits have no effect
    repeat (5) @(negedge clk);
    chk(status_o[2] == 1, "R5 empty holds", status_o[2], 1);
    ack(5'b11010);
    chk(status_o[2] == 1, "R6 zero bit keeps", status_o[2], 1);
    ack(5'b00100);
    chk(status_o[2] == 0, "R5 ack clears", status_o[2], 0);

    // R7 and R6 set beats clear
    rx_done_i = 1; ack_we_i = 1; ack_i = 5'b00010;
    @(negedge clk);
    rx_done_i = 0; ack_we_i = 0; ack_i = 0;
    chk(status_o[1] == 1, "R6 set wins / R7 rx", status_o[1], 1);

    // R9 masking and steering
    chk(irq_o == 0, "R9 masked", irq_o, 0);
    chk(irq_oe_o == 4'b0001, "R9 oe0", irq_oe_o, 1);
    mask_i = 5'b00010; #1;
    chk(irq_o == 4'b0001, "R9 pin0", irq_o, 1);
    int_sel_i = 2; #1;
    chk(irq_o == 4'b0100, "R9 pin2", irq_o, 4);
    chk(irq_oe_o == 4'b0100, "R9 oe2", irq_oe_o, 4);
    @(negedge clk);
    ack(5'b00010);
    chk(irq_o == 0, "R9 released", irq_o, 0);
    mask_i = 0;

    // R8 early-receive threshold
    erx_thresh_i = 100; rx_cnt_i = 200; rx_active_i = 0;
    @(negedge clk);
    chk(status_o[3] == 0, "R8 inactive", status_o[3], 0);
    rx_active_i = 1; rx_cnt_i = 100;
    @(negedge clk);
    chk(status_o[3] == 0, "R8 equal", status_o[3], 0);
    rx_cnt_i = 101;
    @(negedge clk);
    rx_active_i = 0;
    chk(status_o[3] == 1, "R8 above", status_o[3], 1);
    ack(5'b01000);

    // R10 full depth in order
    for (int i = 0; i < DEPTH; i++) tx_pulse(PKT_W'(DEPTH - 1 - i), 5'b0, 1'b0);
    chk(done_valid_o == 1, "R10 full", done_valid_o, 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk(done_pkt_o == PKT_W'(DEPTH - 1 - i), "R10 order", done_pkt_o, DEPTH - 1 - i);
      ack(5'b00001);
    end
    chk(done_valid_o == 0, "R10 empty", done_valid_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule